// File: doc/BRIEF.md
# Integer Pipeline Forwarding and Load-Use Interlock

This block is the hazard control for a five-stage in-order integer pipeline: fetch, decode with register read, execute, memory and write-back. Registers are read in the second stage and written in the fifth. The block receives the instruction words held in four stages: decode, the execute input register, the execute/memory register and the memory/write-back register. From these it computes the bypass multiplexer selects the datapath needs. There are selects for the two ALU operands, for the branch zero-test operand, and for store data. Store data is covered twice: once while the store is in execute, and again as it enters data memory.

A loaded value reaches the end of the memory stage one cycle too late for an instruction that needs it in execute. The block detects that case and raises a stall. The surrounding pipeline answers the stall by holding the PC and the fetch/decode register, loading an all-zero no-op into the execute input register, and letting write-back continue. The block itself is purely combinational. The ALU, the memories and the register file stay outside it.

Top module: `fwd_hazard_unit`

## Requirements
- R1: With the all-zero word (opcode 0x00, every field 0) in all four stages, every select is 00 and the stall is 0.
- R2: Select codes are 00 register file, 01 ALU result in EX/MEM, 10 ALU result in MEM/WB, 11 load data in MEM/WB. Operand A uses the rs field (bits 25:21) of the instruction in execute when its opcode is 0x00, 0x08..0x0F, 0x23 or 0x2B. It is 01 when the EX/MEM instruction writes that register from the ALU, and otherwise 10 when the MEM/WB instruction does. Opcode 0x00 writes bits 15:11; opcodes 0x08..0x0F write bits 20:16.
- R3: Any select is 11 when the MEM/WB instruction is a load (opcode 0x23, destination bits 20:16) of that register and the EX/MEM instruction does not write it.
- R4: The EX/MEM instruction has priority over the MEM/WB instruction. If the EX/MEM instruction is a load of the register, the select is 00.
- R5: A source field of 0 never produces a nonzero select.
- R6: Operand B uses the rt field (bits 20:16) and forwards only when the execute opcode is 0x00. For any other opcode it is 00.
- R7: The zero-test select forwards rs only for branch opcodes 0x04 and 0x05. For any other opcode it is 00.
- R8: The execute-stage store-data select forwards rt only for store opcode 0x2B, using the same codes and priority.
- R9: The memory-stage store-data select is 11 exactly when EX/MEM holds a store whose rt is nonzero and MEM/WB holds a load to that register. Otherwise it is 00.
- R10: The stall is 1 exactly when the execute instruction is a load with a nonzero destination, and the decode instruction uses that register in one of two ways. The first is as rs for opcodes 0x00, 0x08..0x0F, 0x23, 0x2B, 0x04 or 0x05. The second is as rt for opcode 0x00. A store that uses the loaded register only as its data does not stall.
- R11: Stores (0x2B), branches (0x04/0x05) and other opcodes such as 0x02 write no register and never serve as a forwarding source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_instr | input | 32 | Instruction in decode (IF/ID register) |
| ex_instr | input | 32 | Instruction at the execute input (ID/EX register) |
| mem_instr | input | 32 | Instruction in EX/MEM |
| wb_instr | input | 32 | Instruction in MEM/WB |
| ex_sel_a | output | 2 | ALU operand A select |
| ex_sel_b | output | 2 | ALU operand B select |
| ex_sel_z | output | 2 | Branch zero-test operand select |
| ex_sel_sd | output | 2 | Store-data select while the store is in execute |
| mem_sel_sd | output | 2 | Store-data select at the data-memory write input |
| ld_stall | output | 1 | Hold PC and IF/ID and insert a no-op into ID/EX |

## Verification
The checker's assertions hold on every cycle. They confirm that each nonzero select points at a stage holding the right kind of writer. They also confirm that operand B and the zero-test select stay quiet for opcodes that do not use them, that register 0 is never forwarded, and that a stall appears only behind a load. Only the bench's instruction sequences can show the actual timing. That covers the one-bubble recovery after a load-use stall, the switch from 01 to 10 as a producer advances, the EX/MEM-over-MEM/WB priority, and the loaded value reaching a store at the memory stage with no stall. The bench checks these by comparing every output, every cycle, with a behavioural model of the pipeline.

// File: rtl/fhu_pkg.sv
package fhu_pkg;

   typedef enum logic [1:0] {
      SEL_RF        = 2'b00,
      SEL_EXMEM_ALU = 2'b01,
      SEL_MEMWB_ALU = 2'b10,
      SEL_MEMWB_LD  = 2'b11
   } fsel_e;

   localparam logic [5:0] OPC_REG   = 6'h00;
   localparam logic [5:0] OPC_LOAD  = 6'h23;
   localparam logic [5:0] OPC_STORE = 6'h2B;
   localparam logic [5:0] OPC_BRZ   = 6'h04;
   localparam logic [5:0] OPC_BRNZ  = 6'h05;
   localparam logic [2:0] OPC_IMM_HI = 3'b001;

   // per-instruction usage class
   typedef struct packed {
      logic rd_rs;      // rs feeds the ALU
      logic rd_rt_alu;  // rt feeds the ALU
      logic rd_rt_sd;   // rt is store data
      logic is_branch;  // rs is the zero-test operand
      logic is_load;    // writes dst from memory
      logic wr_alu;     // writes dst from the ALU
   } cls_t;

   localparam int unsigned NSTG   = 4;
   localparam int unsigned ST_ID  = 0;
   localparam int unsigned ST_EX  = 1;
   localparam int unsigned ST_MEM = 2;
   localparam int unsigned ST_WB  = 3;

   localparam int unsigned NSEL   = 4;
   localparam int unsigned SL_A   = 0;
   localparam int unsigned SL_B   = 1;
   localparam int unsigned SL_Z   = 2;
   localparam int unsigned SL_SD  = 3;

endpackage

// File: rtl/fhu_decode.sv
module fhu_decode
   import fhu_pkg::*;
#(
   parameter int unsigned INSTR_W = 32,
   parameter int unsigned OP_W    = 6,
   parameter int unsigned REG_W   = 5
) (
   input  logic [INSTR_W-1:0] instr,
   output logic [REG_W-1:0]   rs,
   output logic [REG_W-1:0]   rt,
   output logic [REG_W-1:0]   dst,
   output cls_t               cls
);
   localparam int unsigned OP_LSB = INSTR_W - OP_W;
   localparam int unsigned RS_LSB = OP_LSB - REG_W;
   localparam int unsigned RT_LSB = RS_LSB - REG_W;
   localparam int unsigned RD_LSB = RT_LSB - REG_W;

   logic [OP_W-1:0]  opc;
   logic [REG_W-1:0] rd;
   logic             unused_low_bits;

   assign opc = instr[INSTR_W-1:OP_LSB];
   assign rs  = instr[RS_LSB +: REG_W];
   assign rt  = instr[RT_LSB +: REG_W];
   assign rd  = instr[RD_LSB +: REG_W];
   assign unused_low_bits = ^instr[RD_LSB-1:0];

   always_comb begin
      cls = '0;
      dst = '0;
      if (opc == OPC_REG) begin
         cls.rd_rs     = 1'b1;
         cls.rd_rt_alu = 1'b1;
         cls.wr_alu    = 1'b1;
         dst           = rd;
      end else if (opc[OP_W-1:OP_W-3] == OPC_IMM_HI) begin
         cls.rd_rs  = 1'b1;
         cls.wr_alu = 1'b1;
         dst        = rt;
      end else if (opc == OPC_LOAD) begin
         cls.rd_rs   = 1'b1;
         cls.is_load = 1'b1;
         dst         = rt;
      end else if (opc == OPC_STORE) begin
         cls.rd_rs    = 1'b1;
         cls.rd_rt_sd = 1'b1;
      end else if (opc == OPC_BRZ || opc == OPC_BRNZ) begin
         cls.is_branch = 1'b1;
      end
   end

endmodule

// File: rtl/fhu_src_sel.sv
module fhu_src_sel
   import fhu_pkg::*;
#(
   parameter int unsigned REG_W = 5
) (
   input  logic [REG_W-1:0] src,
   input  logic             use_src,
   input  logic [REG_W-1:0] new_dst,
   input  logic             new_alu,
   input  logic             new_ld,
   input  logic [REG_W-1:0] old_dst,
   input  logic             old_alu,
   input  logic             old_ld,
   output logic [1:0]       sel
);
   fsel_e pick;

   always_comb begin
      pick = SEL_RF;
      if (use_src && src != '0) begin
         if ((new_alu || new_ld) && new_dst == src) begin
            // newest writer owns the register; a load there cannot be bypassed
            pick = new_alu ? SEL_EXMEM_ALU : SEL_RF;
         end else if (old_alu && old_dst == src) begin
            pick = SEL_MEMWB_ALU;
         end else if (old_ld && old_dst == src) begin
            pick = SEL_MEMWB_LD;
         end
      end
   end

   assign sel = pick;

endmodule

// File: rtl/fhu_load_use.sv
module fhu_load_use
   import fhu_pkg::*;
#(
   parameter int unsigned REG_W     = 5,
   parameter bit          STORE_FWD = 1'b1
) (
   input  logic [REG_W-1:0] id_rs,
   input  logic [REG_W-1:0] id_rt,
   input  cls_t             id_cls,
   input  logic [REG_W-1:0] ex_dst,
   input  cls_t             ex_cls,
   output logic             stall
);
   logic ld_live;
   logic rs_hit;
   logic rt_hit;
   logic sd_hit;

   assign ld_live = ex_cls.is_load && (ex_dst != '0);
   assign rs_hit  = (id_cls.rd_rs || id_cls.is_branch) && (id_rs == ex_dst);
   assign rt_hit  = id_cls.rd_rt_alu && (id_rt == ex_dst);

   generate
      if (STORE_FWD) begin : g_sd_bypass
         // loaded data reaches the store at the memory stage instead
         assign sd_hit = 1'b0;
      end else begin : g_sd_stall
         assign sd_hit = id_cls.rd_rt_sd && (id_rt == ex_dst);
      end
   endgenerate

   assign stall = ld_live && (rs_hit || rt_hit || sd_hit);

endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit
   import fhu_pkg::*;
#(
   parameter int unsigned INSTR_W   = 32,
   parameter int unsigned OP_W      = 6,
   parameter int unsigned REG_W     = 5,
   parameter bit          STORE_FWD = 1'b1
) (
   input  logic [INSTR_W-1:0] id_instr,
   input  logic [INSTR_W-1:0] ex_instr,
   input  logic [INSTR_W-1:0] mem_instr,
   input  logic [INSTR_W-1:0] wb_instr,
   output logic [1:0]         ex_sel_a,
   output logic [1:0]         ex_sel_b,
   output logic [1:0]         ex_sel_z,
   output logic [1:0]         ex_sel_sd,
   output logic [1:0]         mem_sel_sd,
   output logic               ld_stall
);
   localparam int FIELD_FLOOR = int'(INSTR_W) - int'(OP_W) - 3 * int'(REG_W);

   generate
      if (OP_W != 6) begin : g_bad_opw
         $error("fwd_hazard_unit: opcode width must be 6");
      end
      if (FIELD_FLOOR < 1) begin : g_bad_fields
         $error("fwd_hazard_unit: instruction too narrow for three register fields");
      end
   endgenerate

   logic [NSTG-1:0][INSTR_W-1:0] stg_instr;
   logic [NSTG-1:0][REG_W-1:0]   dec_rs;
   logic [NSTG-1:0][REG_W-1:0]   dec_rt;
   logic [NSTG-1:0][REG_W-1:0]   dec_dst;
   cls_t [NSTG-1:0]              dec_cls;

   assign stg_instr[ST_ID]  = id_instr;
   assign stg_instr[ST_EX]  = ex_instr;
   assign stg_instr[ST_MEM] = mem_instr;
   assign stg_instr[ST_WB]  = wb_instr;

   generate
      for (genvar g = 0; g < NSTG; g++) begin : g_dec
         fhu_decode #(
            .INSTR_W (INSTR_W),
            .OP_W    (OP_W),
            .REG_W   (REG_W)
         ) u_dec (
            .instr (stg_instr[g]),
            .rs    (dec_rs[g]),
            .rt    (dec_rt[g]),
            .dst   (dec_dst[g]),
            .cls   (dec_cls[g])
         );
      end
   endgenerate

   // execute-stage consumers: operand A, operand B, zero test, store data
   logic [NSEL-1:0][REG_W-1:0] sel_src;
   logic [NSEL-1:0]            sel_use;
   logic [NSEL-1:0][1:0]       sel_out;

   assign sel_src[SL_A]  = dec_rs[ST_EX];
   assign sel_use[SL_A]  = dec_cls[ST_EX].rd_rs;
   assign sel_src[SL_B]  = dec_rt[ST_EX];
   assign sel_use[SL_B]  = dec_cls[ST_EX].rd_rt_alu;
   assign sel_src[SL_Z]  = dec_rs[ST_EX];
   assign sel_use[SL_Z]  = dec_cls[ST_EX].is_branch;
   assign sel_src[SL_SD] = dec_rt[ST_EX];
   assign sel_use[SL_SD] = dec_cls[ST_EX].rd_rt_sd;

   generate
      for (genvar s = 0; s < NSEL; s++) begin : g_sel
         fhu_src_sel #(
            .REG_W (REG_W)
         ) u_sel (
            .src     (sel_src[s]),
            .use_src (sel_use[s]),
            .new_dst (dec_dst[ST_MEM]),
            .new_alu (dec_cls[ST_MEM].wr_alu),
            .new_ld  (dec_cls[ST_MEM].is_load),
            .old_dst (dec_dst[ST_WB]),
            .old_alu (dec_cls[ST_WB].wr_alu),
            .old_ld  (dec_cls[ST_WB].is_load),
            .sel     (sel_out[s])
         );
      end
   endgenerate

   assign ex_sel_a  = sel_out[SL_A];
   assign ex_sel_b  = sel_out[SL_B];
   assign ex_sel_z  = sel_out[SL_Z];
   assign ex_sel_sd = sel_out[SL_SD];

   // memory-stage store data: only a load one ahead can still be pending
   generate
      if (STORE_FWD) begin : g_mem_sd
         fhu_src_sel #(
            .REG_W (REG_W)
         ) u_mem_sd (
            .src     (dec_rt[ST_MEM]),
            .use_src (dec_cls[ST_MEM].rd_rt_sd),
            .new_dst ('0),
            .new_alu (1'b0),
            .new_ld  (1'b0),
            .old_dst (dec_dst[ST_WB]),
            .old_alu (1'b0),
            .old_ld  (dec_cls[ST_WB].is_load),
            .sel     (mem_sel_sd)
         );
      end else begin : g_no_mem_sd
         assign mem_sel_sd = 2'b00;
      end
   endgenerate

   fhu_load_use #(
      .REG_W     (REG_W),
      .STORE_FWD (STORE_FWD)
   ) u_lu (
      .id_rs  (dec_rs[ST_ID]),
      .id_rt  (dec_rt[ST_ID]),
      .id_cls (dec_cls[ST_ID]),
      .ex_dst (dec_dst[ST_EX]),
      .ex_cls (dec_cls[ST_EX]),
      .stall  (ld_stall)
   );

   logic unused_dec;
   assign unused_dec = ^{dec_rs, dec_rt, dec_dst, dec_cls};

endmodule

// File: rtl/fhu_chk.sv
module fhu_chk
   import fhu_pkg::*;
#(
   parameter int unsigned INSTR_W = 32,
   parameter int unsigned OP_W    = 6,
   parameter int unsigned REG_W   = 5
) (
   input logic [INSTR_W-1:0] id_instr,
   input logic [INSTR_W-1:0] ex_instr,
   input logic [INSTR_W-1:0] mem_instr,
   input logic [INSTR_W-1:0] wb_instr,
   input logic [1:0]         ex_sel_a,
   input logic [1:0]         ex_sel_b,
   input logic [1:0]         ex_sel_z,
   input logic [1:0]         ex_sel_sd,
   input logic [1:0]         mem_sel_sd,
   input logic               ld_stall
);
   localparam int unsigned OP_LSB = INSTR_W - OP_W;
   localparam int unsigned RS_LSB = OP_LSB - REG_W;

   logic [OP_W-1:0]  ex_op, mem_op, wb_op;
   logic [REG_W-1:0] ex_rs;
   logic             unused_chk;

   assign ex_op  = ex_instr[INSTR_W-1:OP_LSB];
   assign mem_op = mem_instr[INSTR_W-1:OP_LSB];
   assign wb_op  = wb_instr[INSTR_W-1:OP_LSB];
   assign ex_rs  = ex_instr[RS_LSB +: REG_W];
   assign unused_chk = ^{id_instr, ex_instr[RS_LSB-1:0], mem_instr[OP_LSB-1:0], wb_instr[OP_LSB-1:0]};

   always_comb begin
      // R6: operand B is bypassed only for register-register ALU work
      if (ex_op != OPC_REG)
         p_selb_rr_only_r6: assert (ex_sel_b == 2'b00) else $error("operand B forwarded for non-RR op");
      // R5: register 0 is never bypassed
      if (ex_rs == '0)
         p_zero_src_r5: assert (ex_sel_a == 2'b00 && ex_sel_z == 2'b00) else $error("r0 forwarded");
      // R3: load-data code needs a load in MEM/WB
      if (ex_sel_a == 2'b11 || ex_sel_b == 2'b11 || ex_sel_z == 2'b11 || ex_sel_sd == 2'b11)
         p_ld_code_r3: assert (wb_op == OPC_LOAD) else $error("load data selected without load");
      // R2: EX/MEM code needs an ALU writer there
      if (ex_sel_a == 2'b01)
         p_exmem_alu_r2: assert (mem_op == OPC_REG || mem_op[OP_W-1:OP_W-3] == OPC_IMM_HI) else $error("EX/MEM code without ALU writer");
      // R10: stall only behind a load
      if (ld_stall)
         p_stall_load_r10: assert (ex_op == OPC_LOAD) else $error("stall without load in execute");
      // R9: memory-stage store bypass needs store then load
      if (mem_sel_sd != 2'b00)
         p_mem_sd_r9: assert (mem_op == OPC_STORE && wb_op == OPC_LOAD) else $error("bad memory-stage store bypass");
      // R7: zero-test select only for branches
      if (ex_sel_z != 2'b00)
         p_brz_only_r7: assert (ex_op == OPC_BRZ || ex_op == OPC_BRNZ) else $error("zero test forwarded for non-branch");
   end

endmodule

bind fwd_hazard_unit fhu_chk #(
   .INSTR_W (INSTR_W),
   .OP_W    (OP_W),
   .REG_W   (REG_W)
) u_chk (
   .id_instr   (id_instr),
   .ex_instr   (ex_instr),
   .mem_instr  (mem_instr),
   .wb_instr   (wb_instr),
   .ex_sel_a   (ex_sel_a),
   .ex_sel_b   (ex_sel_b),
   .ex_sel_z   (ex_sel_z),
   .ex_sel_sd  (ex_sel_sd),
   .mem_sel_sd (mem_sel_sd),
   .ld_stall   (ld_stall)
);

// File: tb/sim_fwd_hazard_unit.sv
module sim_fwd_hazard_unit;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 200000;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [31:0] id_i, ex_i, mem_i, wb_i;
   logic [1:0]  sa, sb, sz, ssd, msd;
   logic        stl;

   fwd_hazard_unit u0 (
      .id_instr (id_i), .ex_instr (ex_i), .mem_instr (mem_i), .wb_instr (wb_i),
      .ex_sel_a (sa), .ex_sel_b (sb), .ex_sel_z (sz), .ex_sel_sd (ssd),
      .mem_sel_sd (msd), .ld_stall (stl)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   logic [31:0] prog[$];

   // ---- instruction builders
   function automatic logic [31:0] rr(int d, int s, int t);
      return {6'h00, 5'(s), 5'(t), 5'(d), 11'h0};
   endfunction
   function automatic logic [31:0] im(int t, int s);
      return {6'h08, 5'(s), 5'(t), 16'h0};
   endfunction
   function automatic logic [31:0] ld(int t, int s);
      return {6'h23, 5'(s), 5'(t), 16'h0};
   endfunction
   function automatic logic [31:0] st(int t, int s);
      return {6'h2B, 5'(s), 5'(t), 16'h0};
   endfunction
   function automatic logic [31:0] bz(int s);
      return {6'h04, 5'(s), 5'd0, 16'h0};
   endfunction
   function automatic logic [31:0] jm(int s, int t);
      return {6'h02, 5'(s), 5'(t), 16'h0};
   endfunction

   // ---- behavioural reference
   function automatic int opc(logic [31:0] w); return int'(w[31:26]); endfunction
   function automatic int frs(logic [31:0] w); return int'(w[25:21]); endfunction
   function automatic int frt(logic [31:0] w); return int'(w[20:16]); endfunction
   // 0 none, 1 ALU writer, 2 load
   function automatic int kind(logic [31:0] w);
      int o = opc(w);
      if (o == 0 || (o >= 8 && o <= 15)) return 1;
      if (o == 'h23) return 2;
      return 0;
   endfunction
   function automatic int dest(logic [31:0] w);
      if (opc(w) == 0) return int'(w[15:11]);
      if (kind(w) != 0) return frt(w);
      return 0;
   endfunction
   function automatic bit alu_rs(logic [31:0] w);
      int o = opc(w);
      return o == 0 || (o >= 8 && o <= 15) || o == 'h23 || o == 'h2B;
   endfunction
   function automatic bit is_br(logic [31:0] w);
      return opc(w) == 4 || opc(w) == 5;
   endfunction
   function automatic int pick(int src, logic [31:0] nw, logic [31:0] od);
      if (src == 0) return 0;
      if (kind(nw) != 0 && dest(nw) == src) return (kind(nw) == 1) ? 1 : 0;
      if (kind(od) != 0 && dest(od) == src) return (kind(od) == 1) ? 2 : 3;
      return 0;
   endfunction
   function automatic bit exp_stall(logic [31:0] idw, logic [31:0] exw);
      int d = dest(exw);
      if (kind(exw) != 2 || d == 0) return 0;
      if ((alu_rs(idw) || is_br(idw)) && frs(idw) == d) return 1;
      if (opc(idw) == 0 && frt(idw) == d) return 1;
      return 0;
   endfunction
   // requirement tag for a select comparison
   function automatic string tag_for(string base, bit used, int src, int e,
                                     logic [31:0] nw, logic [31:0] od);
      if (!used) return base;
      if (src == 0) return "R5";
      if (kind(nw) != 0 && dest(nw) == src && kind(od) != 0 && dest(od) == src) return "R4";
      if (kind(nw) == 2 && dest(nw) == src) return "R4";
      if (e == 3) return "R3";
      if (kind(nw) == 0 && (frt(nw) == src || frs(nw) == src) && opc(nw) != 0) return "R11";
      return base;
   endfunction

   task automatic chk(string tg, int act, int exp, string what);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d (id=%h ex=%h mem=%h wb=%h)",
                  tg, what, act, exp, id_i, ex_i, mem_i, wb_i);
      end
   endtask

   task automatic compare_all();
      int e;
      e = alu_rs(ex_i) ? pick(frs(ex_i), mem_i, wb_i) : 0;
      chk(tag_for("R2", alu_rs(ex_i), frs(ex_i), e, mem_i, wb_i), int'(sa), e, "sel_a");
      e = (opc(ex_i) == 0) ? pick(frt(ex_i), mem_i, wb_i) : 0;
      chk(tag_for("R6", opc(ex_i) == 0, frt(ex_i), e, mem_i, wb_i), int'(sb), e, "sel_b");
      e = is_br(ex_i) ? pick(frs(ex_i), mem_i, wb_i) : 0;
      chk(tag_for("R7", is_br(ex_i), frs(ex_i), e, mem_i, wb_i), int'(sz), e, "sel_z");
      e = (opc(ex_i) == 'h2B) ? pick(frt(ex_i), mem_i, wb_i) : 0;
      chk(tag_for("R8", opc(ex_i) == 'h2B, frt(ex_i), e, mem_i, wb_i), int'(ssd), e, "sel_sd");
      e = (opc(mem_i) == 'h2B && frt(mem_i) != 0 && kind(wb_i) == 2 && dest(wb_i) == frt(mem_i)) ? 3 : 0;
      chk("R9", int'(msd), e, "mem_sel_sd");
      chk("R10", int'(stl), int'(exp_stall(id_i, ex_i)), "ld_stall");
   endtask

   // one clock of the bench pipeline, stall honoured as the surrounding core would
   task automatic run_prog(int extra);
      int tail = extra;
      while (prog.size() > 0 || tail > 0) begin
         bit s;
         @(negedge clk);
         compare_all();
         s = exp_stall(id_i, ex_i);
         @(posedge clk);
         #1;
         wb_i  = mem_i;
         mem_i = ex_i;
         if (s) ex_i = 32'h0;
         else begin
            ex_i = id_i;
            if (prog.size() > 0) id_i = prog.pop_front();
            else begin id_i = 32'h0; tail--; end
         end
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      id_i = 0; ex_i = 0; mem_i = 0; wb_i = 0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      // R1: all-zero pipeline gives quiet outputs
      chk("R1", int'(sa),  0, "reset sel_a");
      chk("R1", int'(sb),  0, "reset sel_b");
      chk("R1", int'(sz),  0, "reset sel_z");
      chk("R1", int'(ssd), 0, "reset sel_sd");
      chk("R1", int'(msd), 0, "reset mem_sel_sd");
      chk("R1", int'(stl), 0, "reset ld_stall");

      // R2 chain: one ahead then two ahead
      prog = '{rr(1,2,3), rr(4,1,3), rr(6,1,7), im(8,1), rr(9,3,1)};
      run_prog(5);
      // R3/R10 load-use: one bubble then load data
      prog = '{ld(1,2), rr(4,1,6), rr(6,7,1)};
      run_prog(5);
      // R9 load then store of the loaded register: no stall
      prog = '{ld(4,1), st(4,1)};
      run_prog(5);
      // R10 load then store using it as base: stall
      prog = '{ld(4,1), st(5,4)};
      run_prog(5);
      // R4 priority: newer writer wins
      prog = '{rr(1,2,3), rr(1,4,5), rr(6,1,1), ld(2,3), im(2,3), rr(7,2,2)};
      run_prog(5);
      // R5 register zero
      prog = '{rr(0,1,2), im(0,1), rr(3,0,0), bz(0)};
      run_prog(5);
      // R7 branch zero-test, and load before branch
      prog = '{rr(1,2,3), bz(1), ld(1,2), bz(1), jm(0,0), bz(1)};
      run_prog(5);
      // R8 store data two behind an ALU writer
      prog = '{rr(7,1,2), jm(0,0), st(7,3), im(5,1), st(5,5)};
      run_prog(5);
      // R11 non-writers are never sources
      prog = '{st(5,1), rr(6,5,5), bz(5), rr(6,5,5), jm(5,5), rr(7,5,5)};
      run_prog(5);

      // mixed traffic over a small register set
      for (int i = 0; i < 4000; i++) begin
         int k = $urandom_range(0, 5);
         int a = $urandom_range(0, 3), b = $urandom_range(0, 3), c = $urandom_range(0, 3);
         case (k)
            0: prog.push_back(rr(a, b, c));
            1: prog.push_back(im(a, b));
            2: prog.push_back(ld(a, b));
            3: prog.push_back(st(a, b));
            4: prog.push_back(bz(a));
            default: prog.push_back(jm(a, b));
         endcase
      end
      run_prog(5);
      finish_run();
   end

endmodule